// File: doc/BRIEF.md
# AES Inverse Column-Mixing Execution Slice

This block executes one vector operation: it applies the AES InvMixColumns transform to a 128-bit round key and merges the result into a wider destination register. Each request carries the source lane, the old destination contents, a flag for the encoding form (legacy or VEX), the 4-bit extra-register field and the processor's operating mode. One cycle later the block returns the register value to write back, a write enable, and an undefined-opcode flag.

The low lane of the result is the transformed key. The destination bits above the lane are handled according to the encoding form. The legacy form leaves them as they were. The VEX form clears them. Two checks decide whether the request is legal:
- The operating mode must be 32-bit or 64-bit.
- In the VEX form, the extra-register field must be all ones.

An illegal request raises the undefined-opcode flag, drops the write enable and returns the old destination unchanged.

Control is a two-state machine:
- `S_IDLE`: no result is presented.
- `S_RESULT`: a result is presented for one cycle.

The transitions are:
- `T_ACCEPT`: goes to `S_RESULT` on any cycle with `req_valid` high, from either state.
- `T_DRAIN`: goes to `S_IDLE` on any cycle with `req_valid` low.

Top module: `aesimc_unit`

## Requirements
- R1: The low 128 bits of `rsp_value` are InvMixColumns of `src_lane`. Byte k of the lane is bits [8k+7:8k], and bytes 4c..4c+3 form column c with byte 4c in row 0. Each output byte in row r is 0E·a[r] ^ 0B·a[r+1] ^ 0D·a[r+2] ^ 09·a[r+3] (indices mod 4), computed in GF(2^8) with polynomial 0x11B. Applying forward MixColumns to the output gives back the source.
- R2: For the legacy form (`vex_form`=0), `rsp_value[255:128]` equals `dst_old[255:128]`.
- R3: For a legal VEX-form request (`vex_form`=1), `rsp_value[255:128]` is zero.
- R4: For a VEX-form request with `extra_reg` other than 4'b1111, the block sets `rsp_ud`=1 and `rsp_write`=0, and `rsp_value` equals `dst_old`.
- R5: `op_mode` encodes the mode as 2'b00 for 16-bit, 2'b01 for 32-bit, 2'b10 for 64-bit and 2'b11 for reserved. A 16-bit or reserved mode gives `rsp_ud`=1 and `rsp_write`=0, with `rsp_value`=`dst_old`. The 32-bit and 64-bit modes are legal.
- R6: In the legacy form, `extra_reg` has no effect on `rsp_ud`, `rsp_write` or `rsp_value`.
- R7: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high (`T_ACCEPT`, then `T_DRAIN`). Reset clears `rsp_valid`, `rsp_write`, `rsp_ud` and `rsp_value`.
- R8: Requests on consecutive cycles each produce their own result, one per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| src_lane | input | 128 | Round key to transform |
| dst_old | input | 256 | Current destination register contents |
| vex_form | input | 1 | 1 = VEX form, 0 = legacy form |
| extra_reg | input | 4 | Extra-register field of the encoding |
| op_mode | input | 2 | Operating mode (00 16-bit, 01 32-bit, 10 64-bit, 11 reserved) |
| rsp_valid | output | 1 | Result present |
| rsp_value | output | 256 | Value to write back to the destination |
| rsp_write | output | 1 | Write enable for the destination |
| rsp_ud | output | 1 | Undefined-opcode exception |

## Verification
On every cycle, the assertions check:
- the one-cycle valid timing;
- that the undefined-opcode flag and the write enable are never high together;
- that an illegal field or mode always leads to the exception;
- that the upper bits are kept in the legacy form and cleared in the VEX form.

The arithmetic of the transform can only be shown by the bench's scenarios:
- the known column pairs;
- the round trip through forward MixColumns on varied keys;
- the ordering of back-to-back requests;
- the checks that the extra field is ignored in the legacy form.

// File: rtl/aesimc_pkg.sv
package aesimc_pkg;

    typedef enum logic [1:0] {
        MODE_16  = 2'b00,
        MODE_32  = 2'b01,
        MODE_64  = 2'b10,
        MODE_RSV = 2'b11
    } mode_t;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_RESULT = 1'b1
    } state_t;

    // Multiply by x in GF(2^8), polynomial 0x11B
    function automatic logic [7:0] gf_x(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gf_m09(input logic [7:0] b);
        logic [7:0] x2, x4, x8;
        x2 = gf_x(b); x4 = gf_x(x2); x8 = gf_x(x4);
        return x8 ^ b;
    endfunction

    function automatic logic [7:0] gf_m0b(input logic [7:0] b);
        logic [7:0] x2, x4, x8;
        x2 = gf_x(b); x4 = gf_x(x2); x8 = gf_x(x4);
        return x8 ^ x2 ^ b;
    endfunction

    function automatic logic [7:0] gf_m0d(input logic [7:0] b);
        logic [7:0] x2, x4, x8;
        x2 = gf_x(b); x4 = gf_x(x2); x8 = gf_x(x4);
        return x8 ^ x4 ^ b;
    endfunction

    function automatic logic [7:0] gf_m0e(input logic [7:0] b);
        logic [7:0] x2, x4, x8;
        x2 = gf_x(b); x4 = gf_x(x2); x8 = gf_x(x4);
        return x8 ^ x4 ^ x2;
    endfunction

endpackage

// File: rtl/aesimc_column.sv
module aesimc_column
    import aesimc_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic [8*ROWS-1:0] col_in,
    output logic [8*ROWS-1:0] col_out
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int I0 = r % ROWS;
        localparam int I1 = (r + 1) % ROWS;
        localparam int I2 = (r + 2) % ROWS;
        localparam int I3 = (r + 3) % ROWS;
        assign col_out[8*r +: 8] = gf_m0e(col_in[8*I0 +: 8])
                                 ^ gf_m0b(col_in[8*I1 +: 8])
                                 ^ gf_m0d(col_in[8*I2 +: 8])
                                 ^ gf_m09(col_in[8*I3 +: 8]);
    end
endmodule

// File: rtl/aesimc_lane.sv
module aesimc_lane #(
    parameter int LANE_W = 128,
    parameter int ROWS   = 4
) (
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_out
);
    localparam int COL_W = 8 * ROWS;
    localparam int COLS  = LANE_W / COL_W;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        aesimc_column #(.ROWS(ROWS)) u_col (
            .col_in  (lane_in [COL_W*c +: COL_W]),
            .col_out (lane_out[COL_W*c +: COL_W])
        );
    end
endmodule

// File: rtl/aesimc_legal.sv
module aesimc_legal
    import aesimc_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic               vex_form,
    input  logic [FIELD_W-1:0] extra_reg,
    input  logic [1:0]         op_mode,
    output logic               legal
);
    mode_t mode;
    logic  mode_ok;
    logic  field_ok;

    always_comb begin
        mode = mode_t'(op_mode);
        unique case (mode)
            MODE_32, MODE_64: mode_ok = 1'b1;
            default:          mode_ok = 1'b0;
        endcase
        field_ok = !vex_form || (extra_reg == {FIELD_W{1'b1}});
        legal    = mode_ok && field_ok;
    end
endmodule

// File: rtl/aesimc_unit.sv
module aesimc_unit
    import aesimc_pkg::*;
#(
    parameter int DEST_W  = 256,
    parameter int LANE_W  = 128,
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LANE_W-1:0]  src_lane,
    input  logic [DEST_W-1:0]  dst_old,
    input  logic               vex_form,
    input  logic [FIELD_W-1:0] extra_reg,
    input  logic [1:0]         op_mode,
    output logic               rsp_valid,
    output logic [DEST_W-1:0]  rsp_value,
    output logic               rsp_write,
    output logic               rsp_ud
);
    localparam int UP_W = DEST_W - LANE_W;

    state_t            state, state_nx;
    logic [LANE_W-1:0] lane_res;
    logic              legal;
    logic [DEST_W-1:0] merged;

    aesimc_lane #(.LANE_W(LANE_W), .ROWS(4)) u_lane (
        .lane_in  (src_lane),
        .lane_out (lane_res)
    );

    aesimc_legal #(.FIELD_W(FIELD_W)) u_legal (
        .vex_form  (vex_form),
        .extra_reg (extra_reg),
        .op_mode   (op_mode),
        .legal     (legal)
    );

    always_comb begin
        if (!legal)
            merged = dst_old;
        else if (vex_form)
            merged = {{UP_W{1'b0}}, lane_res};
        else
            merged = {dst_old[DEST_W-1:LANE_W], lane_res};
    end

    // T_ACCEPT / T_DRAIN
    always_comb begin
        unique case (state)
            S_IDLE:   state_nx = req_valid ? S_RESULT : S_IDLE;
            S_RESULT: state_nx = req_valid ? S_RESULT : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_value <= '0;
            rsp_write <= 1'b0;
            rsp_ud    <= 1'b0;
        end else if (req_valid) begin
            rsp_value <= merged;
            rsp_write <= legal;
            rsp_ud    <= !legal;
        end else begin
            rsp_write <= 1'b0;
            rsp_ud    <= 1'b0;
        end
    end

    assign rsp_valid = (state == S_RESULT);

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_ud_blocks_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ud |-> !rsp_write);
    assert_bad_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vex_form && extra_reg != {FIELD_W{1'b1}}) |=> (rsp_ud && rsp_value == $past(dst_old)));
    assert_bad_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op_mode == 2'b00 || op_mode == 2'b11)) |=> (rsp_ud && !rsp_write));
    assert_vex_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vex_form && extra_reg == {FIELD_W{1'b1}} && (op_mode == 2'b01 || op_mode == 2'b10))
        |=> (rsp_write && rsp_value[DEST_W-1:LANE_W] == '0));
    assert_legacy_upper_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vex_form) |=> (rsp_value[DEST_W-1:LANE_W] == $past(dst_old[DEST_W-1:LANE_W])));
endmodule

// File: tb/aesimc_unit_bench.sv
module aesimc_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [127:0] src_lane = '0;
    logic [255:0] dst_old = '0;
    logic         vex_form = 1'b0;
    logic [3:0]   extra_reg = 4'hF;
    logic [1:0]   op_mode = 2'b10;
    logic         rsp_valid;
    logic [255:0] rsp_value;
    logic         rsp_write;
    logic         rsp_ud;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    aesimc_unit u_aesimc_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .src_lane(src_lane),
        .dst_old(dst_old), .vex_form(vex_form), .extra_reg(extra_reg), .op_mode(op_mode),
        .rsp_valid(rsp_valid), .rsp_value(rsp_value), .rsp_write(rsp_write), .rsp_ud(rsp_ud)
    );

    localparam int NV = 5;
    localparam logic [127:0] VEC_IN [NV] = '{
        {32'h9d58dc9f, 32'hbca14d8e, 32'hd6d7d5d5, 32'hf8bd7e4d},
        {4{32'h01010101}},
        128'h0,
        {4{32'hc6c6c6c6}},
        {4{32'hffffffff}}
    };
    localparam logic [127:0] VEC_EXP [NV] = '{
        {32'h5c220af2, 32'h455313db, 32'hd5d4d4d4, 32'h4c31262d},
        {4{32'h01010101}},
        128'h0,
        {4{32'hc6c6c6c6}},
        {4{32'hffffffff}}
    };

    function automatic logic [7:0] tb_x(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [127:0] fwd_mix(input logic [127:0] v);
        logic [127:0] o;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] a0, a1, a2, a3;
            a0 = v[32*c +: 8]; a1 = v[32*c+8 +: 8]; a2 = v[32*c+16 +: 8]; a3 = v[32*c+24 +: 8];
            o[32*c    +: 8] = tb_x(a0) ^ tb_x(a1) ^ a1 ^ a2 ^ a3;
            o[32*c+8  +: 8] = a0 ^ tb_x(a1) ^ tb_x(a2) ^ a2 ^ a3;
            o[32*c+16 +: 8] = a0 ^ a1 ^ tb_x(a2) ^ tb_x(a3) ^ a3;
            o[32*c+24 +: 8] = tb_x(a0) ^ a0 ^ a1 ^ a2 ^ tb_x(a3);
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request at a falling edge; sample one cycle later at a falling edge
    task automatic issue(input logic [127:0] s, input logic [255:0] d, input logic vf,
                         input logic [3:0] xr, input logic [1:0] md);
        @(negedge clk);
        req_valid = 1'b1; src_lane = s; dst_old = d; vex_form = vf; extra_reg = xr; op_mode = md;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        logic [255:0] old;
        repeat (3) @(negedge clk);
        check("R7 reset valid", {255'b0, rsp_valid}, 256'b0);
        check("R7 reset value", rsp_value, 256'b0);
        check("R7 reset flags", {254'b0, rsp_write, rsp_ud}, 256'b0);
        rst_n = 1'b1;

        // Vector table, legacy form, 64-bit mode
        for (int i = 0; i < NV; i++) begin
            old = {128'hA5A5_0000_1111_2222_3333_4444_5555_6666 ^ 128'(i), 128'hDEAD};
            issue(VEC_IN[i], old, 1'b0, 4'h3, 2'b10);
            check("R1 vector lane", {128'b0, rsp_value[127:0]}, {128'b0, VEC_EXP[i]});
            check("R2 vector upper", {128'b0, rsp_value[255:128]}, {128'b0, old[255:128]});
            check("R7 vector valid/write", {254'b0, rsp_valid, rsp_write}, 256'd3);
        end

        // Round trip through forward MixColumns, VEX form, 32-bit mode
        for (int i = 0; i < 8; i++) begin
            logic [127:0] s;
            s = {$urandom, $urandom, $urandom, $urandom};
            old = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            issue(s, old, 1'b1, 4'hF, 2'b01);
            check("R1 round trip", {128'b0, fwd_mix(rsp_value[127:0])}, {128'b0, s});
            check("R3 vex upper zero", {128'b0, rsp_value[255:128]}, 256'b0);
        end

        // R4: VEX with bad extra field
        old = {8{32'h600DF00D}};
        issue(VEC_IN[0], old, 1'b1, 4'hE, 2'b10);
        check("R4 bad field value", rsp_value, old);
        check("R4 bad field flags", {254'b0, rsp_ud, rsp_write}, 256'd2);
        issue(VEC_IN[0], old, 1'b1, 4'h0, 2'b01);
        check("R4 zero field flags", {254'b0, rsp_ud, rsp_write}, 256'd2);

        // R5: 16-bit and reserved modes
        issue(VEC_IN[0], old, 1'b0, 4'hF, 2'b00);
        check("R5 16-bit value", rsp_value, old);
        check("R5 16-bit flags", {254'b0, rsp_ud, rsp_write}, 256'd2);
        issue(VEC_IN[0], old, 1'b1, 4'hF, 2'b11);
        check("R5 reserved flags", {254'b0, rsp_ud, rsp_write}, 256'd2);
        issue(VEC_IN[0], old, 1'b1, 4'hF, 2'b01);
        check("R5 32-bit legal", {254'b0, rsp_ud, rsp_write}, 256'd1);

        // R6: legacy ignores extra field
        issue(VEC_IN[0], old, 1'b0, 4'h0, 2'b01);
        check("R6 legacy field ignored flags", {254'b0, rsp_ud, rsp_write}, 256'd1);
        check("R6 legacy field ignored value", rsp_value, {old[255:128], VEC_EXP[0]});

        // R7: idle cycle gives no valid
        @(negedge clk);
        check("R7 idle no valid", {255'b0, rsp_valid}, 256'b0);

        // R8: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; src_lane = VEC_IN[0]; dst_old = old; vex_form = 1'b1; extra_reg = 4'hF; op_mode = 2'b10;
        @(negedge clk);
        src_lane = VEC_IN[3]; vex_form = 1'b0;
        check("R8 first of pair", rsp_value, {128'b0, VEC_EXP[0]});
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 second of pair", rsp_value, {old[255:128], VEC_EXP[3]});
        check("R8 second valid", {255'b0, rsp_valid}, 256'd1);
        @(negedge clk);
        check("R7 drain after pair", {255'b0, rsp_valid}, 256'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule